// File: doc/BRIEF.md
# In-Place Logarithmic Reduction Engine

The block adds up a vector of N unsigned words, where N is a power of two. It works like N/2 processors that share one register array and step together on a common clock. A start pulse loads the parallel input vector into a working array. The engine then halves the live part of that array once per round, with each live slot taking the sum of the pair of slots it covers. After the last round, slot one holds the total, and a store step moves it into the result register.

A run takes a fixed schedule of 2 + log2(N) steps: one load, log2(N) combine rounds and one store. The engine raises `done` when the store completes and keeps it high until the next accepted start. A step counter output shows how many steps the current or last run has used. Additions wrap modulo 2^W.

Top module: `tree_sum_engine`

## Requirements
- R1: After reset, `done` is 0, `sum` is 0 and `step_count` is 0.
- R2: On an accepted start, the engine loads every word of `vec_in` in the same clock edge. Word k sits at bits [k*W +: W]. Changes to `vec_in` after that edge have no effect on the run's result.
- R3: On completion, `sum` equals the sum of all N input words. The engine reaches it by log2(N) rounds. In round h (counted from 1), every 1-based slot i with i <= N/2^h takes the sum of slots 2i-1 and 2i, and every read of a round happens before any write of that round.
- R4: `done` rises exactly 2 + log2(N) clock edges after the edge that accepts start, counting that edge as the first. At that point `step_count` equals 2 + log2(N).
- R5: `step_count` becomes 1 on the accepting edge and grows by exactly one on each further step of the run. It never exceeds 2 + log2(N).
- R6: A start that arrives while a run is in progress (`done` low and `step_count` not 0) is ignored. The run's latency and result are unchanged.
- R7: While start stays low, `done` stays high and `sum` and `step_count` hold. A start while `done` is high is accepted: on the next edge `done` drops and `step_count` reads 1.
- R8: The smallest configuration, N = 2, completes in 3 steps with the correct sum for every input pair.
- R9: The total wraps modulo 2^W. With all words at 2^W-1, the result is (N*(2^W-1)) mod 2^W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle or finished |
| vec_in | input | N*W | Input words, word k at bits [k*W +: W] |
| sum | output | W | Result register, written at the store step |
| done | output | 1 | High from completion until the next accepted start |
| step_count | output | $clog2(log2(N)+3) | Steps used by the current or last run |

## Verification
The bound checker looks at every cycle. It checks that the step counter advances by one per step and stays within its bound. It checks that a start during a run cannot restart the counter, that `done` rises only at the full step count, and that the result and flag hold until the next accepted start. Only the bench scenarios can show that the stored total is arithmetically right. The bench covers all 256 input pairs on a two-word instance, plus zero, all-ones, one-hot, ramp and random vectors on an eight-word instance with 8-bit words. The same scenarios show that changes to the input vector and a second start during a run do not alter the result.

// File: rtl/tree_sum_pkg.sv
package tree_sum_pkg;
   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_COMBINE  = 2'd1,
      PH_STORE    = 2'd2,
      PH_FINISHED = 2'd3
   } phase_t;

   function automatic int total_steps(input int levels);
      return levels + 2;
   endfunction
endpackage

// File: rtl/tree_sum_ctrl.sv
module tree_sum_ctrl
   import tree_sum_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int RW     = 2,
   parameter int CW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          copy_en,
   output logic          comb_en,
   output logic          store_en,
   output logic [RW-1:0] round,
   output logic          finished,
   output logic [CW-1:0] steps
);
   phase_t phase_q;
   logic   accept;

   // A new run may begin only from rest or after a finished run (R6, R7)
   assign accept   = start && (phase_q == PH_IDLE || phase_q == PH_FINISHED);
   assign copy_en  = accept;
   assign comb_en  = (phase_q == PH_COMBINE);
   assign store_en = (phase_q == PH_STORE);
   assign finished = (phase_q == PH_FINISHED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         round   <= RW'(1);
         steps   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE, PH_FINISHED: begin
               if (accept) begin
                  phase_q <= PH_COMBINE;
                  round   <= RW'(1);
                  steps   <= CW'(1);
               end
            end
            PH_COMBINE: begin
               steps <= steps + CW'(1);
               if (round == RW'(LEVELS)) phase_q <= PH_STORE;
               else                      round   <= round + RW'(1);
            end
            PH_STORE: begin
               steps   <= steps + CW'(1);
               phase_q <= PH_FINISHED;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/tree_sum_array.sv
module tree_sum_array #(
   parameter int N  = 8,
   parameter int W  = 16,
   parameter int RW = 2
) (
   input  logic           clk,
   input  logic           copy_en,
   input  logic           comb_en,
   input  logic [RW-1:0]  round,
   input  logic [N*W-1:0] vec_in,
   output logic [W-1:0]   head
);
   logic [W-1:0] slot_q [N];

   for (genvar i = 0; i < N; i++) begin : g_slot
      logic [W-1:0] q;
      assign slot_q[i] = q;
      if (i < N/2) begin : g_lane
         // 0-based lane i covers 1-based slots 2i+1 and 2i+2 (R3)
         logic active;
         assign active = (i < (N >> round));
         always_ff @(posedge clk) begin
            if (copy_en)               q <= vec_in[i*W +: W];
            else if (comb_en && active) q <= slot_q[2*i] + slot_q[2*i+1];
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (copy_en) q <= vec_in[i*W +: W];
         end
      end
   end

   assign head = slot_q[0];
endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine #(
   parameter int N  = 8,
   parameter int W  = 16,
   localparam int LEVELS = $clog2(N),
   localparam int RW     = $clog2(LEVELS + 1),
   localparam int CW     = $clog2(LEVELS + 3)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N*W-1:0] vec_in,
   output logic [W-1:0]   sum,
   output logic           done,
   output logic [CW-1:0]  step_count
);
   if (N < 2 || N > 64 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("tree_sum_engine: N must be a power of two from 2 to 64");
   end
   if (W < 1) begin : g_bad_w
      $error("tree_sum_engine: W must be at least 1");
   end

   logic          copy_en, comb_en, store_en, finished;
   logic [RW-1:0] round;
   logic [W-1:0]  head;
   logic [W-1:0]  sum_q;

   tree_sum_ctrl #(.LEVELS(LEVELS), .RW(RW), .CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .copy_en  (copy_en),
      .comb_en  (comb_en),
      .store_en (store_en),
      .round    (round),
      .finished (finished),
      .steps    (step_count)
   );

   tree_sum_array #(.N(N), .W(W), .RW(RW)) u_array (
      .clk     (clk),
      .copy_en (copy_en),
      .comb_en (comb_en),
      .round   (round),
      .vec_in  (vec_in),
      .head    (head)
   );

   // Only slot one feeds the result register, at the store step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sum_q <= '0;
      else if (store_en) sum_q <= head;
   end

   assign sum  = sum_q;
   assign done = finished;
endmodule

// File: rtl/tree_sum_checker.sv
module tree_sum_checker #(
   parameter int N = 8,
   parameter int W = 16,
   localparam int LEVELS = $clog2(N),
   localparam int CW     = $clog2(LEVELS + 3)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          done,
   input logic [W-1:0]  sum,
   input logic [CW-1:0] step_count
);
   localparam logic [CW-1:0] LAST = CW'(LEVELS + 2);

   assert_step_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_count != '0 && !done) |=> step_count == $past(step_count) + CW'(1));

   assert_step_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_count <= LAST);

   assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> step_count == LAST);

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(sum) && $stable(step_count)));

   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> (!done && step_count == CW'(1)));

   assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && step_count != '0 && start) |=> step_count != CW'(1));
endmodule

bind tree_sum_engine tree_sum_checker #(.N(N), .W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .done       (done),
   .sum        (sum),
   .step_count (step_count)
);

// File: tb/tree_sum_engine_tb.sv
`timescale 1ns/1ps
module tree_sum_engine_tb;
   localparam int NB = 8, WB = 8, LB = 3;
   localparam int NS = 2, WS = 4, LS = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              start_b = 1'b0;
   logic [NB*WB-1:0]  vec_b = '0;
   logic [WB-1:0]     sum_b;
   logic              done_b;
   logic [2:0]        steps_b;

   logic              start_s = 1'b0;
   logic [NS*WS-1:0]  vec_s = '0;
   logic [WS-1:0]     sum_s;
   logic              done_s;
   logic [1:0]        steps_s;

   int checks = 0;
   int errors = 0;

   tree_sum_engine #(.N(NB), .W(WB)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start_b), .vec_in(vec_b),
      .sum(sum_b), .done(done_b), .step_count(steps_b));

   tree_sum_engine #(.N(NS), .W(WS)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .start(start_s), .vec_in(vec_s),
      .sum(sum_s), .done(done_s), .step_count(steps_s));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [WB-1:0] ref_big(input logic [NB*WB-1:0] v);
      logic [WB-1:0] acc = '0;
      for (int k = 0; k < NB; k++) acc = acc + v[k*WB +: WB];
      return acc;
   endfunction

   // disturb: one cycle into the run, raise start again and invert vec_in (R2, R6)
   task automatic run_big(input logic [NB*WB-1:0] v, input bit disturb, input string req);
      logic [WB-1:0] exp_sum;
      exp_sum = ref_big(v);
      @(negedge clk);
      vec_b = v; start_b = 1'b1;
      @(negedge clk);
      start_b = 1'b0;
      chk(!done_b && steps_b == 3'd1, "R7 restart clears done", {done_b, steps_b}, 1);
      for (int k = 0; k < LB; k++) begin
         if (disturb && k == 0) begin start_b = 1'b1; vec_b = ~v; end
         @(negedge clk);
         start_b = 1'b0;
      end
      chk(!done_b, "R4 done not early", done_b, 0);
      @(negedge clk);
      chk(done_b, "R4 done on time", done_b, 1);
      chk(steps_b == 3'(LB + 2), "R5 step count", steps_b, LB + 2);
      chk(sum_b == exp_sum, req, sum_b, exp_sum);
   endtask

   task automatic run_small(input logic [NS*WS-1:0] v);
      logic [WS-1:0] exp_sum;
      exp_sum = v[3:0] + v[7:4];
      @(negedge clk);
      vec_s = v; start_s = 1'b1;
      @(negedge clk);
      start_s = 1'b0;
      for (int k = 0; k < LS; k++) @(negedge clk);
      chk(!done_s, "R8 small done not early", done_s, 0);
      @(negedge clk);
      chk(done_s && steps_s == 2'(LS + 2), "R8 small latency", {done_s, steps_s}, 4'b0111);
      chk(sum_s == exp_sum, "R8 small sum", sum_s, exp_sum);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [NB*WB-1:0] v;
      logic [WB-1:0]    held;
      repeat (3) @(negedge clk);
      chk(!done_b && sum_b == '0 && steps_b == '0, "R1 reset state big", {done_b, sum_b, steps_b}, 0);
      chk(!done_s && sum_s == '0 && steps_s == '0, "R1 reset state small", {done_s, sum_s, steps_s}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done_b && steps_b == '0, "R1 idle after reset", {done_b, steps_b}, 0);

      run_big('0, 1'b0, "R3 all-zero sum");
      run_big({NB*WB{1'b1}}, 1'b0, "R9 all-ones wrap");
      chk(sum_b == 8'd248, "R9 wrap value", sum_b, 248);
      for (int p = 0; p < NB; p++) begin
         v = '0;
         v[p*WB +: WB] = WB'(8'h81 + p);
         run_big(v, 1'b0, "R3 one-hot word");
      end
      for (int k = 0; k < NB; k++) v[k*WB +: WB] = WB'(k * 37 + 11);
      run_big(v, 1'b0, "R3 ramp sum");
      for (int k = 0; k < NB; k++) v[k*WB +: WB] = WB'(8'hF0 + k);
      run_big(v, 1'b0, "R9 overflow sum");
      for (int r = 0; r < 200; r++) begin
         v = {$urandom, $urandom};
         run_big(v, 1'b0, "R3 random sum");
      end
      v = 64'h0123_4567_89AB_CDEF;
      run_big(v, 1'b1, "R2 R6 disturbed run sum");

      held = sum_b;
      repeat (5) @(negedge clk);
      chk(done_b && sum_b == held && steps_b == 3'(LB + 2), "R7 hold after done",
          {done_b, sum_b}, {1'b1, held});

      for (int a = 0; a < 256; a++) run_small(8'(a));

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule